// File: doc/BRIEF.md
# Burst Write Master with Underrun Pausing

This block is a bus manager for a single-layer AHB-Lite system. It copies a run of 32-bit words from its own small write-data queue into memory as incrementing bursts. A caller loads a start address and a word count and pulses a start strobe. The block then issues one address phase per word and presents the matching data in the cycle that follows. It pulses a completion flag once the final word has been written.

The queue is filled from its own push port at whatever rate the upstream source manages. When the queue has no word for the next beat of an open burst, the block keeps the burst alive. It drives the pause code and parks the bus address on the beat still to come. When a word arrives, it carries on with a sequential beat. It does not close the burst and open a new one.

A burst is closed and a fresh one opened only where the next address lands on a 1 KB boundary. Wait states from the subordinate freeze everything the manager drives until the subordinate is ready again.

Top module: `burst_wr_master`

## Requirements
- R1: Every address phase of a beat drives write direction high, a size code of 3'b010 (32-bit word) and a burst code of 3'b001 (incrementing, undefined length). Transfer codes are idle 2'b00, pause 2'b01, first beat 2'b10 and sequential beat 2'b11.
- R2: A run of N words produces exactly N accepted beats. Beat k (from 0) carries address start + 4k.
- R3: The first beat of a run is coded 2'b10. A beat whose address has its low 10 bits all zero is also coded 2'b10. Every other beat is coded 2'b11.
- R4: If the queue is empty when the next beat of an open burst is due, the block drives the pause code 2'b01 with the address of that upcoming beat. When data returns it continues with 2'b11 at that same address. Idle never appears inside a burst, except at a 1 KB boundary.
- R5: The pause code is never driven outside a burst. Idle (2'b00) is driven after reset, before the first beat of a run, after the last beat, and at a 1 KB boundary when no word is ready.
- R6: While the ready input is low, the transfer code, the address and the write data all hold their values from the previous cycle.
- R7: The write data for a beat appears in the cycle after its address phase is accepted. It is the next word in push order.
- R8: The done flag is high for exactly one cycle. That cycle is the one after the final data phase completes with ready high. A run of zero words raises done in the cycle after the start strobe and issues no beat.
- R9: When the queue already holds every word of the run before the start strobe, the run has no pause cycle and exactly one first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start strobe, taken while no run is in progress |
| start_addr_i | input | 32 | Byte address of the first word |
| beat_count_i | input | 8 | Number of words in the run |
| wr_push_i | input | 1 | Push a word into the write queue |
| wr_data_i | input | 32 | Word to push |
| wr_full_o | output | 1 | Queue full; pushes are dropped while high |
| hready_i | input | 1 | Subordinate ready |
| htrans_o | output | 2 | Transfer code |
| haddr_o | output | 32 | Bus address |
| hwrite_o | output | 1 | Write direction |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst kind |
| hwdata_o | output | 32 | Write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Some faults corrupt the beat counter or the next-address register. These show at the ports on the very next accepted beat, either as a wrong address or as an extra or missing beat before done. A wrong in-burst flag shows within one cycle of a queue underrun. It appears as idle followed by a new first-beat code where a pause belonged, or as a pause outside any burst. A queue pointer fault shows as wrong or reordered write data on the next completed data phase. A broken wait-state enable shows as a moved address or data value in the first stalled cycle. The sweep therefore crosses run lengths with three supply rates and two ready patterns, and adds a boundary-straddling run and an empty run.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } htrans_e;

  localparam logic [2:0] SIZE_WORD  = 3'b010;
  localparam logic [2:0] BURST_INCR = 3'b001;
endpackage

// File: rtl/bwm_fifo.sv
module bwm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         avail_next_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign head_o  = mem_q[rd_q];

  always_comb begin
    cnt_n = cnt_q + CW'(push_ok) - CW'(pop_i);
    wr_n  = wr_q;
    rd_n  = rd_q;
    if (push_ok) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop_i)   rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
  end

  assign avail_next_o = (cnt_n != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0)); // R7
endmodule

// File: rtl/bwm_seq.sv
module bwm_seq
  import bwm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int KB_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  beat_count_i,
  input  logic              hready_i,
  input  logic              avail_next_i,
  output logic [1:0]        htrans_o,
  output logic [ADDR_W-1:0] haddr_o,
  output logic              pop_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  htrans_e           htrans_q, htrans_n;
  logic [ADDR_W-1:0] haddr_q, haddr_n, next_addr_q, next_addr_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic              active_q, active_n;
  logic              in_burst_q, in_burst_n;
  logic              last_dp_q, last_dp_n;
  logic              done_q, done_n;
  logic              is_beat, beat_acc, at_bound, issue, hold_busy;

  assign is_beat   = (htrans_q == TR_NSEQ) || (htrans_q == TR_SEQ);
  assign beat_acc  = hready_i && is_beat;
  assign at_bound  = (next_addr_q[KB_BITS-1:0] == '0);
  assign issue     = (rem_q != '0) && avail_next_i;
  assign hold_busy = (rem_q != '0) && in_burst_q && !at_bound;

  always_comb begin
    htrans_n    = htrans_q;
    haddr_n     = haddr_q;
    next_addr_n = next_addr_q;
    rem_n       = rem_q;
    active_n    = active_q;
    in_burst_n  = in_burst_q;
    last_dp_n   = last_dp_q;
    done_n      = 1'b0;
    if (!active_q) begin
      if (go_i) begin
        next_addr_n = start_addr_i;
        rem_n       = beat_count_i;
        active_n    = (beat_count_i != '0);
        done_n      = (beat_count_i == '0);
      end
    end else if (hready_i) begin
      if (last_dp_q) begin
        done_n    = 1'b1;
        active_n  = 1'b0;
        last_dp_n = 1'b0;
      end
      if (beat_acc && (rem_q == '0)) last_dp_n = 1'b1;
      haddr_n = next_addr_q;
      if (issue) begin
        htrans_n    = (in_burst_q && !at_bound) ? TR_SEQ : TR_NSEQ;
        next_addr_n = next_addr_q + STEP;
        rem_n       = rem_q - CNT_W'(1);
        in_burst_n  = 1'b1;
      end else if (hold_busy) begin
        htrans_n = TR_BUSY;
      end else begin
        htrans_n   = TR_IDLE;
        in_burst_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htrans_q    <= TR_IDLE;
      haddr_q     <= '0;
      next_addr_q <= '0;
      rem_q       <= '0;
      active_q    <= 1'b0;
      in_burst_q  <= 1'b0;
      last_dp_q   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      htrans_q    <= htrans_n;
      haddr_q     <= haddr_n;
      next_addr_q <= next_addr_n;
      rem_q       <= rem_n;
      active_q    <= active_n;
      in_burst_q  <= in_burst_n;
      last_dp_q   <= last_dp_n;
      done_q      <= done_n;
    end
  end

  assign htrans_o = htrans_q;
  assign haddr_o  = haddr_q;
  assign pop_o    = beat_acc;
  assign done_o   = done_q;

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> ($stable(htrans_q) && $stable(haddr_q))); // R6
  AST_BUSY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_BUSY) |-> ($past(htrans_q) != TR_IDLE)); // R5
  AST_BUSY_NOT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_BUSY) |-> (haddr_q[KB_BITS-1:0] != '0)); // R3
  AST_NEXT_BEAT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    beat_acc |=> (((htrans_q == TR_SEQ) || (htrans_q == TR_BUSY)) ?
                  (haddr_q == $past(haddr_q) + STEP) : 1'b1)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
endmodule

// File: rtl/burst_wr_master.sv
module burst_wr_master
  import bwm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int KB_BITS    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  beat_count_i,
  input  logic              wr_push_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  input  logic              hready_i,
  output logic [1:0]        htrans_o,
  output logic [ADDR_W-1:0] haddr_o,
  output logic              hwrite_o,
  output logic [2:0]        hsize_o,
  output logic [2:0]        hburst_o,
  output logic [DATA_W-1:0] hwdata_o,
  output logic              done_o
);
  logic              pop;
  logic              avail_next;
  logic [DATA_W-1:0] head;
  logic [DATA_W-1:0] hwdata_q;

  bwm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (wr_push_i),
    .push_data_i  (wr_data_i),
    .pop_i        (pop),
    .head_o       (head),
    .full_o       (wr_full_o),
    .avail_next_o (avail_next)
  );

  bwm_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .KB_BITS(KB_BITS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go_i),
    .start_addr_i (start_addr_i),
    .beat_count_i (beat_count_i),
    .hready_i     (hready_i),
    .avail_next_i (avail_next),
    .htrans_o     (htrans_o),
    .haddr_o      (haddr_o),
    .pop_o        (pop),
    .done_o       (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hwdata_q <= '0;
    else if (pop) hwdata_q <= head;
  end

  assign hwdata_o = hwdata_q;
  assign hwrite_o = 1'b1;
  assign hsize_o  = SIZE_WORD;
  assign hburst_o = BURST_INCR;

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> $stable(hwdata_q)); // R6
endmodule

// File: tb/burst_wr_master_bench.sv
`timescale 1ns/1ps
module burst_wr_master_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        go;
  logic [31:0] start_addr;
  logic [7:0]  beat_count;
  logic        push;
  logic [31:0] push_data;
  logic        full;
  logic        hready;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic [31:0] hwdata;
  logic        done;

  burst_wr_master u_burst_wr_master (
    .clk(clk), .rst_n(rst_n), .go_i(go), .start_addr_i(start_addr),
    .beat_count_i(beat_count), .wr_push_i(push), .wr_data_i(push_data),
    .wr_full_o(full), .hready_i(hready), .htrans_o(htrans), .haddr_o(haddr),
    .hwrite_o(hwrite), .hsize_o(hsize), .hburst_o(hburst), .hwdata_o(hwdata),
    .done_o(done)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0;
  int acc_cnt, wr_idx, busy_cnt, nseq_cnt, done_due, cur_count, tid;
  int feed_left, pushed, feed_mode, hr_mode;
  logic [31:0] base;
  bit saw_idle, done_seen, mon_en;
  logic [1:0]  prev_htrans;
  logic [31:0] prev_haddr, prev_hwdata;
  bit prev_hready, dp_prev;
  logic [7:0] lfsr;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (test %0d)", req, act, exp, tid);
    end
  endtask

  function automatic logic [31:0] word_of(input int t, input int i);
    return {t[15:0], i[15:0]};
  endfunction

  // ready and supply drivers
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    hready = (hr_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
    push = 1'b0;
    if (feed_left > 0 && !full && (feed_mode != 1 || (cyc % 3) == 0)) begin
      push = 1'b1;
      push_data = word_of(tid, pushed);
      pushed++;
      feed_left--;
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    bit dp_now;
    #1;
    dp_now = (prev_htrans[1] && prev_hready) || (dp_prev && !prev_hready);
    if (mon_en) begin
      if (!prev_hready) begin
        check(htrans == prev_htrans && haddr == prev_haddr, "R6 addr-phase hold",
              {htrans, haddr}, {prev_htrans, prev_haddr});
        if (dp_now) check(hwdata == prev_hwdata, "R6 data hold", hwdata, prev_hwdata);
      end
      if (dp_now && hready) begin
        check(hwdata == word_of(tid, wr_idx), "R7 write data", hwdata, word_of(tid, wr_idx));
        wr_idx++;
        if (wr_idx == cur_count) done_due = cyc + 1;
      end
      if (htrans == 2'b01) begin
        busy_cnt++;
        check(acc_cnt > 0 && acc_cnt < cur_count && !saw_idle && haddr[9:0] != 0,
              "R5 pause outside burst", acc_cnt, cur_count);
        check(haddr == base + 32'(4 * acc_cnt), "R4 pause address", haddr, base + 32'(4 * acc_cnt));
      end
      if (htrans == 2'b00 && acc_cnt > 0 && acc_cnt < cur_count)
        check(haddr[9:0] == 0, "R4 idle inside burst", haddr, 0);
      if (htrans[1] && hready) begin
        logic [1:0] ek;
        ek = (acc_cnt == 0 || haddr[9:0] == 0 || saw_idle) ? 2'b10 : 2'b11;
        check(acc_cnt < cur_count, "R2 beat count", acc_cnt, cur_count);
        check(haddr == base + 32'(4 * acc_cnt), "R2 beat address", haddr, base + 32'(4 * acc_cnt));
        check(htrans == ek, "R3 beat code", htrans, ek);
        check(hwrite && hsize == 3'b010 && hburst == 3'b001, "R1 attributes",
              {hwrite, hsize, hburst}, {1'b1, 3'b010, 3'b001});
        if (htrans == 2'b10) nseq_cnt++;
        acc_cnt++;
        saw_idle = 0;
      end
      if (htrans == 2'b00 && hready) saw_idle = 1;
      if (cyc == done_due) check(done == 1'b1, "R8 done timing", done, 1);
      else if (done) check(1'b0, "R8 stray done", cyc, done_due);
      if (done) done_seen = 1;
    end
    prev_htrans = htrans; prev_haddr = haddr; prev_hready = hready;
    prev_hwdata = hwdata; dp_prev = dp_now;
    cyc++;
  end

  task automatic run(input logic [31:0] b, input int n, input int fm, input int hm, input int exp_nseq);
    tid++;
    @(negedge clk);
    acc_cnt = 0; wr_idx = 0; busy_cnt = 0; nseq_cnt = 0; done_due = -1;
    saw_idle = 0; done_seen = 0; pushed = 0;
    cur_count = n; base = b; feed_mode = fm; hr_mode = hm;
    feed_left = n;
    if (fm == 2) begin
      while (feed_left > 0) @(negedge clk);
      @(negedge clk);
    end
    start_addr = b; beat_count = 8'(n); go = 1'b1;
    if (n == 0) done_due = cyc + 1;
    @(negedge clk);
    go = 1'b0;
    for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
    check(done_seen, "R8 run completes", done_seen, 1);
    @(negedge clk); @(negedge clk);
    check(acc_cnt == n, "R2 total beats", acc_cnt, n);
    check(wr_idx == n, "R7 total data", wr_idx, n);
    if (n > 0) check(nseq_cnt == exp_nseq, "R4 single burst", nseq_cnt, exp_nseq);
    if (fm == 2) check(busy_cnt == 0, "R9 no pause when stocked", busy_cnt, 0);
    if (fm == 1 && hm == 0 && n >= 3) check(busy_cnt > 0, "R4 pause on underrun", busy_cnt, 1);
    check(htrans == 2'b00, "R5 idle after run", htrans, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; start_addr = '0; beat_count = '0;
    push = 1'b0; push_data = '0; hready = 1'b1; lfsr = 8'h5a;
    feed_left = 0; pushed = 0; feed_mode = 0; hr_mode = 0; tid = 0;
    cur_count = 0; acc_cnt = 0; wr_idx = 0; done_due = -1; base = '0;
    mon_en = 0; prev_hready = 1; dp_prev = 0; prev_htrans = 0; prev_haddr = 0; prev_hwdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(htrans == 2'b00, "R5 reset idle", htrans, 0);
    check(done == 1'b0, "R8 reset done low", done, 0);
    check(full == 1'b0, "R7 reset queue empty", full, 0);
    mon_en = 1;
    for (int hm = 0; hm < 2; hm++) begin
      for (int n = 1; n <= 4; n++) run(32'h100, n, 2, hm, 1);
      for (int n = 1; n <= 9; n += 2) run(32'h200 + 32'(16 * n), n, 0, hm, 1);
      for (int n = 3; n <= 9; n += 3) run(32'h104, n, 1, hm, 1);
      run(32'h3F8, 5, 0, hm, 2);
      run(32'h3F8, 5, 1, hm, 2);
    end
    run(32'h40, 0, 0, 0, 0);
    run(32'h7F4, 3, 2, 1, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule